// File: doc/BRIEF.md
# Ping-Pong Block Transfer Pipeline Sequencer

This controller runs a three-stage streaming pipeline over a run of equal-sized data blocks. For each block, two upload channels each copy one input block from slow memory into a local buffer, a compute engine turns that pair of inputs into one output block, and a download channel writes the output back to slow memory. Local storage is split into two buffer sets, A and B. Each set has two input buffers and one output buffer. Consecutive blocks alternate between the two sets, so work on neighbouring blocks never touches the same buffers.

A run is divided into steps numbered 0 to N+1. In step s the sequencer starts the uploads of block s, the compute of block s-1 and the download of block s-2, skipping every term that falls outside 0..N-1. Step 0 only loads. Step 1 loads and computes. Middle steps keep all three stages busy at once. Step N computes the last block and downloads the one before it. Step N+1 only downloads. The sequencer issues one-cycle start pulses with a block index and a buffer-set select to each unit. It moves to the next step only when every unit it started has reported done. The run length is given at start, so one instance serves any count from 1 up to its maximum.

Top module: `pingpong_seq`

## Requirements
- R1: Out of reset and while idle, every start output, `busy_o` and `finished_o` are 0.
- R2: Both upload channels are started in the same cycle with the same block index. The buffer-set select of every start equals bit 0 of its block index (0 = set A, 1 = set B).
- R3: In step s (0 to N+1), the sequencer starts uploads of block s when s < N, compute of block s-1 when 1 <= s <= N, and download of block s-2 when 2 <= s <= N+1. All starts of a step fall in the same cycle.
- R4: A step ends only when every unit started in it has pulsed done. Dones may arrive in any order and with any latency of at least one cycle after the start. A unit is never restarted before its previous done.
- R5: Over a run, every block is uploaded by both channels, computed and downloaded exactly once. A compute starts only after both uploads of its block are done. A download starts only after its block's compute is done. An upload or compute reusing a buffer set starts only after the compute or download, respectively, of the block two earlier is done.
- R6: For N = 1 and N = 2 the empty steps are skipped, and no start pulse ever carries a block index outside 0..N-1.
- R7: `finished_o` is high for exactly one cycle: the cycle after the edge at which the last download's done is sampled. `busy_o` falls on that same edge.
- R8: `start_i` is ignored while `busy_o` is high. A start with `blk_count_i` equal to 0 or above MAX_BLOCKS is also ignored.
- R9: The first start pulses appear in the cycle after the edge that accepts `start_i`. Each later step's pulses appear in the cycle after the edge that samples its last outstanding done. A step therefore lasts one cycle plus the longest latency among its active units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run when idle |
| blk_count_i | input | CNT_W | Number of blocks N in the run, sampled at start |
| upa_start_o | output | 1 | Start pulse for upload channel A |
| upb_start_o | output | 1 | Start pulse for upload channel B |
| up_blk_o | output | IDX_W | Block index for both uploads |
| up_set_o | output | 1 | Buffer set for the uploads (0 = A, 1 = B) |
| upa_done_i | input | 1 | Upload channel A done pulse |
| upb_done_i | input | 1 | Upload channel B done pulse |
| cmp_start_o | output | 1 | Start pulse for the compute engine |
| cmp_blk_o | output | IDX_W | Block index for the compute |
| cmp_set_o | output | 1 | Buffer set the compute reads and writes |
| cmp_done_i | input | 1 | Compute done pulse |
| dn_start_o | output | 1 | Start pulse for the download channel |
| dn_blk_o | output | IDX_W | Block index for the download |
| dn_set_o | output | 1 | Buffer set whose output buffer is downloaded |
| dn_done_i | input | 1 | Download done pulse |
| busy_o | output | 1 | A run is in progress |
| finished_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The first start pulses are due one cycle after the edge that accepts `start_i`. Every later step lasts one issue cycle plus the longest done latency among the units active in it. The bench rebuilds that per-step sum from R3 and the stub latencies it chose, and compares it with the edge count from acceptance to the appearance of `finished_o`. Start pulses are recorded at each falling edge, before the done pulses seen in the same cycle are credited. This way a start that comes in the same cycle as the done it depends on is reported as an ordering fault.

// File: rtl/pingpong_seq_pkg.sv
package pingpong_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    localparam int NUM_UNITS = 4;
    localparam int U_UPA     = 0;
    localparam int U_UPB     = 1;
    localparam int U_CMP     = 2;
    localparam int U_DN      = 3;

    typedef logic [NUM_UNITS-1:0] unit_vec_t;

    // Units that have work in a given step of an nblk-block run.
    function automatic unit_vec_t step_units(input int step, input int nblk);
        unit_vec_t v;
        v        = '0;
        v[U_UPA] = (step < nblk);
        v[U_UPB] = (step < nblk);
        v[U_CMP] = (step >= 1) && (step <= nblk);
        v[U_DN]  = (step >= 2) && (step <= nblk + 1);
        return v;
    endfunction

endpackage

// File: rtl/pingpong_seq_step_ctrl.sv
module pingpong_seq_step_ctrl
    import pingpong_seq_pkg::*;
#(
    parameter int MAX_BLOCKS = 64,
    parameter int CNT_W      = 7,
    parameter int STEP_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              step_clear_i,
    output seq_state_e        state_o,
    output logic [STEP_W-1:0] step_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              finished_o
);

    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  count_q;
    logic              fin_q;
    logic              accept;
    logic              last_step;

    assign accept    = (state_q == SEQ_IDLE) && start_i &&
                       (count_i != '0) && (count_i <= CNT_W'(MAX_BLOCKS));
    assign last_step = (step_q == (STEP_W'(count_q) + STEP_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            step_q  <= '0;
            count_q <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        count_q <= count_i;
                        step_q  <= '0;
                        state_q <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: state_q <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (step_clear_i) begin
                        if (last_step) begin
                            state_q <= SEQ_IDLE;
                            fin_q   <= 1'b1;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            state_q <= SEQ_ISSUE;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign state_o    = state_q;
    assign step_o     = step_q;
    assign count_o    = count_q;
    assign finished_o = fin_q;

endmodule

// File: rtl/pingpong_seq_pending.sv
module pingpong_seq_pending #(
    parameter int UNITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [UNITS-1:0] mask_i,
    input  logic             track_i,
    input  logic [UNITS-1:0] done_i,
    output logic             clear_o
);

    logic [UNITS-1:0] pend_q;

    for (genvar g = 0; g < UNITS; g++) begin : g_unit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
            end else if (load_i) begin
                pend_q[g] <= mask_i[g];
            end else if (track_i && done_i[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    // The step is over once every outstanding unit is done, counting dones of this cycle.
    assign clear_o = track_i && ((pend_q & ~done_i) == '0);

endmodule

// File: rtl/pingpong_seq.sv
module pingpong_seq
    import pingpong_seq_pkg::*;
#(
    parameter int MAX_BLOCKS = 64,
    parameter int IDX_W      = $clog2(MAX_BLOCKS),
    parameter int CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] blk_count_i,
    output logic             upa_start_o,
    output logic             upb_start_o,
    output logic [IDX_W-1:0] up_blk_o,
    output logic             up_set_o,
    input  logic             upa_done_i,
    input  logic             upb_done_i,
    output logic             cmp_start_o,
    output logic [IDX_W-1:0] cmp_blk_o,
    output logic             cmp_set_o,
    input  logic             cmp_done_i,
    output logic             dn_start_o,
    output logic [IDX_W-1:0] dn_blk_o,
    output logic             dn_set_o,
    input  logic             dn_done_i,
    output logic             busy_o,
    output logic             finished_o
);

    localparam int STEP_W = $clog2(MAX_BLOCKS + 2);

    seq_state_e        state;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  count;
    logic              step_clear;
    logic              issue;
    unit_vec_t         active;
    unit_vec_t         done_vec;
    unit_vec_t         fire;
    logic [IDX_W-1:0]  up_idx;
    logic [IDX_W-1:0]  cmp_idx;
    logic [IDX_W-1:0]  dn_idx;

    pingpong_seq_step_ctrl #(
        .MAX_BLOCKS (MAX_BLOCKS),
        .CNT_W      (CNT_W),
        .STEP_W     (STEP_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .count_i      (blk_count_i),
        .step_clear_i (step_clear),
        .state_o      (state),
        .step_o       (step),
        .count_o      (count),
        .finished_o   (finished_o)
    );

    assign issue    = (state == SEQ_ISSUE);
    assign active   = step_units(int'(step), int'(count));
    assign fire     = issue ? active : '0;
    assign done_vec = {dn_done_i, cmp_done_i, upb_done_i, upa_done_i};

    pingpong_seq_pending #(
        .UNITS (NUM_UNITS)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .load_i  (issue),
        .mask_i  (active),
        .track_i (state == SEQ_WAIT),
        .done_i  (done_vec),
        .clear_o (step_clear)
    );

    // Upload lead, compute lags by one, download by two.
    assign up_idx  = step[IDX_W-1:0];
    assign cmp_idx = step[IDX_W-1:0] - IDX_W'(1);
    assign dn_idx  = step[IDX_W-1:0] - IDX_W'(2);

    assign upa_start_o = fire[U_UPA];
    assign upb_start_o = fire[U_UPB];
    assign cmp_start_o = fire[U_CMP];
    assign dn_start_o  = fire[U_DN];

    assign up_blk_o  = fire[U_UPA] ? up_idx  : '0;
    assign cmp_blk_o = fire[U_CMP] ? cmp_idx : '0;
    assign dn_blk_o  = fire[U_DN]  ? dn_idx  : '0;

    assign up_set_o  = up_blk_o[0];
    assign cmp_set_o = cmp_blk_o[0];
    assign dn_set_o  = dn_blk_o[0];

    assign busy_o = (state != SEQ_IDLE);

endmodule

// File: rtl/pingpong_seq_checker.sv
module pingpong_seq_checker #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             upa_start_o,
    input logic             upb_start_o,
    input logic [IDX_W-1:0] up_blk_o,
    input logic             cmp_start_o,
    input logic [IDX_W-1:0] cmp_blk_o,
    input logic             dn_start_o,
    input logic [IDX_W-1:0] dn_blk_o,
    input logic             busy_o,
    input logic             finished_o
);

    // R1: no unit is started while the sequencer is idle
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(upa_start_o || upb_start_o || cmp_start_o || dn_start_o));

    // R2: the two upload channels always start together
    a_r2_uploads_paired: assert property (@(posedge clk) disable iff (rst)
        (upa_start_o || upb_start_o) |-> (upa_start_o && upb_start_o));

    // R3: compute trails the uploads by one block in a shared step
    a_r3_compute_trails: assert property (@(posedge clk) disable iff (rst)
        (upa_start_o && cmp_start_o) |-> (IDX_W'(cmp_blk_o + IDX_W'(1)) == up_blk_o));

    // R3: download trails the compute by one block in a shared step
    a_r3_download_trails: assert property (@(posedge clk) disable iff (rst)
        (cmp_start_o && dn_start_o) |-> (IDX_W'(dn_blk_o + IDX_W'(1)) == cmp_blk_o));

    // R4: a unit is never pulsed on two consecutive cycles
    a_r4_single_compute: assert property (@(posedge clk) disable iff (rst)
        cmp_start_o |=> !cmp_start_o);

    // R7: finish is a one-cycle pulse
    a_r7_finish_pulse: assert property (@(posedge clk) disable iff (rst)
        finished_o |=> !finished_o);

    // R7: finish comes as busy drops
    a_r7_finish_idle: assert property (@(posedge clk) disable iff (rst)
        finished_o |-> (!busy_o && $past(busy_o)));

    // R8: a run begins only from a start request
    a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind pingpong_seq pingpong_seq_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .upa_start_o (upa_start_o),
    .upb_start_o (upb_start_o),
    .up_blk_o    (up_blk_o),
    .cmp_start_o (cmp_start_o),
    .cmp_blk_o   (cmp_blk_o),
    .dn_start_o  (dn_start_o),
    .dn_blk_o    (dn_blk_o),
    .busy_o      (busy_o),
    .finished_o  (finished_o)
);

// File: tb/pingpong_seq_tb.sv
module pingpong_seq_stub #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  int               lat,
    input  logic             start,
    input  logic [IDX_W-1:0] blk,
    output logic             done,
    output logic             busy,
    output logic [IDX_W-1:0] blk_q
);
    int cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= 0;
            blk_q <= '0;
        end else if (start) begin
            cnt   <= lat;
            blk_q <= blk;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end
    end
    assign done = (cnt == 1);
    assign busy = (cnt != 0);
endmodule

module pingpong_seq_tb;
    localparam int MAXB  = 64;
    localparam int IDX_W = $clog2(MAXB);
    localparam int CNT_W = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [CNT_W-1:0] blk_count_i = '0;
    logic upa_start, upb_start, cmp_start, dn_start;
    logic [IDX_W-1:0] up_blk, cmp_blk, dn_blk;
    logic up_set, cmp_set, dn_set;
    logic upa_done, upb_done, cmp_done, dn_done;
    logic upa_busy, upb_busy, cmp_busy, dn_busy;
    logic [IDX_W-1:0] upa_q, upb_q, cmp_q, dn_q;
    logic busy, finished;
    int lat_a = 1, lat_b = 1, lat_c = 1, lat_d = 1;

    int checks = 0;
    int failures = 0;
    bit finished_run = 0;

    int cnt_a[MAXB], cnt_b[MAXB], cnt_c[MAXB], cnt_d[MAXB];
    bit dn_a[MAXB], dn_b[MAXB], dn_c[MAXB], dn_d[MAXB];
    int range_err, dep_err, set_err, ovl_err, fin_seen;
    int cur_n;

    always #10 clk = ~clk;

    pingpong_seq #(.MAX_BLOCKS(MAXB)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .blk_count_i(blk_count_i),
        .upa_start_o(upa_start), .upb_start_o(upb_start), .up_blk_o(up_blk), .up_set_o(up_set),
        .upa_done_i(upa_done), .upb_done_i(upb_done),
        .cmp_start_o(cmp_start), .cmp_blk_o(cmp_blk), .cmp_set_o(cmp_set), .cmp_done_i(cmp_done),
        .dn_start_o(dn_start), .dn_blk_o(dn_blk), .dn_set_o(dn_set), .dn_done_i(dn_done),
        .busy_o(busy), .finished_o(finished)
    );

    pingpong_seq_stub #(.IDX_W(IDX_W)) s_upa (.clk(clk), .rst(rst), .lat(lat_a), .start(upa_start),
        .blk(up_blk), .done(upa_done), .busy(upa_busy), .blk_q(upa_q));
    pingpong_seq_stub #(.IDX_W(IDX_W)) s_upb (.clk(clk), .rst(rst), .lat(lat_b), .start(upb_start),
        .blk(up_blk), .done(upb_done), .busy(upb_busy), .blk_q(upb_q));
    pingpong_seq_stub #(.IDX_W(IDX_W)) s_cmp (.clk(clk), .rst(rst), .lat(lat_c), .start(cmp_start),
        .blk(cmp_blk), .done(cmp_done), .busy(cmp_busy), .blk_q(cmp_q));
    pingpong_seq_stub #(.IDX_W(IDX_W)) s_dn (.clk(clk), .rst(rst), .lat(lat_d), .start(dn_start),
        .blk(dn_blk), .done(dn_done), .busy(dn_busy), .blk_q(dn_q));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_score(input int n);
        cur_n = n;
        for (int i = 0; i < MAXB; i++) begin
            cnt_a[i] = 0; cnt_b[i] = 0; cnt_c[i] = 0; cnt_d[i] = 0;
            dn_a[i] = 0; dn_b[i] = 0; dn_c[i] = 0; dn_d[i] = 0;
        end
        range_err = 0; dep_err = 0; set_err = 0; ovl_err = 0; fin_seen = 0;
    endtask

    // Called at each falling edge: record starts first, then credit dones.
    task automatic observe();
        int b;
        if (upa_start) begin
            b = int'(up_blk);
            if (upa_busy || upb_busy) ovl_err++;
            if (b >= cur_n) range_err++;
            else begin
                cnt_a[b]++;
                if (up_set != up_blk[0]) set_err++;
                if (b >= 2 && !dn_c[b-2]) dep_err++;
            end
        end
        if (upb_start) begin
            b = int'(up_blk);
            if (b >= cur_n) range_err++; else cnt_b[b]++;
        end
        if (cmp_start) begin
            b = int'(cmp_blk);
            if (cmp_busy) ovl_err++;
            if (b >= cur_n) range_err++;
            else begin
                cnt_c[b]++;
                if (cmp_set != cmp_blk[0]) set_err++;
                if (!(dn_a[b] && dn_b[b])) dep_err++;
                if (b >= 2 && !dn_d[b-2]) dep_err++;
            end
        end
        if (dn_start) begin
            b = int'(dn_blk);
            if (dn_busy) ovl_err++;
            if (b >= cur_n) range_err++;
            else begin
                cnt_d[b]++;
                if (dn_set != dn_blk[0]) set_err++;
                if (!dn_c[b]) dep_err++;
            end
        end
        if (upa_done) dn_a[int'(upa_q)] = 1;
        if (upb_done) dn_b[int'(upb_q)] = 1;
        if (cmp_done) dn_c[int'(cmp_q)] = 1;
        if (dn_done)  dn_d[int'(dn_q)] = 1;
        if (finished) fin_seen++;
    endtask

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected edges from acceptance to finish, built from the step structure (R3, R9).
    function automatic int exp_edges(input int n);
        int tot = 0;
        for (int s = 0; s <= n + 1; s++) begin
            int m = 0;
            if (s < n) m = max2(lat_a, lat_b);
            if (s >= 1 && s <= n) m = max2(m, lat_c);
            if (s >= 2) m = max2(m, lat_d);
            tot += m + 1;
        end
        return tot;
    endfunction

    task automatic run_case(input string name, input int n, input int la, input int lb,
                            input int lc, input int ld, input bit intrude);
        int edges;
        int bad_cnt;
        lat_a = la; lat_b = lb; lat_c = lc; lat_d = ld;
        clear_score(n);
        @(negedge clk);
        start_i = 1'b1;
        blk_count_i = CNT_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        // R9: first pulses in the cycle after the accepting edge
        check(upa_start && upb_start && up_blk == '0 && busy, {name, " R9 first pulse"},
              int'(upa_start), 1);
        observe();
        edges = 0;
        while (!finished && edges < 20000) begin
            @(negedge clk);
            edges++;
            if (intrude && edges == 3) begin
                start_i = 1'b1;
                blk_count_i = CNT_W'(3);
            end else begin
                start_i = 1'b0;
            end
            observe();
        end
        start_i = 1'b0;
        check(edges == exp_edges(n), {name, " R9 step timing"}, edges, exp_edges(n));
        check(!busy, {name, " R7 busy drops with finish"}, int'(busy), 0);
        bad_cnt = 0;
        for (int i = 0; i < n; i++)
            if (cnt_a[i] != 1 || cnt_b[i] != 1 || cnt_c[i] != 1 || cnt_d[i] != 1) bad_cnt++;
        check(bad_cnt == 0, {name, " R5 each block once"}, bad_cnt, 0);
        check(dep_err == 0, {name, " R5 dependency order"}, dep_err, 0);
        check(ovl_err == 0, {name, " R4 no restart before done"}, ovl_err, 0);
        check(range_err == 0, {name, " R6 index range"}, range_err, 0);
        check(set_err == 0, {name, " R2 set select"}, set_err, 0);
        @(negedge clk);
        observe();
        check(!finished && fin_seen == 1, {name, " R7 single finish pulse"}, fin_seen, 1);
        check(!busy && !upa_start && !cmp_start && !dn_start, {name, " R8 stays idle"},
              int'(busy), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !finished && !upa_start && !upb_start && !cmp_start && !dn_start,
              "R1 reset state", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !upa_start && !cmp_start && !dn_start, "R1 idle after reset",
              int'(busy), 0);
    endtask

    task automatic t_bad_count(input int n);
        int seen = 0;
        @(negedge clk);
        start_i = 1'b1;
        blk_count_i = CNT_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (busy || upa_start || cmp_start || dn_start || finished) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R8 bad count ignored", seen, 0);
    endtask

    initial begin
        t_reset();
        run_case("basic", 4, 1, 1, 1, 1, 0);
        run_case("ooo_a", 6, 5, 1, 3, 2, 0);
        run_case("ooo_b", 5, 1, 4, 1, 6, 0);
        run_case("single", 1, 2, 2, 2, 2, 0);
        run_case("double", 2, 1, 3, 2, 1, 0);
        run_case("busy_start", 3, 2, 2, 2, 2, 1);
        t_bad_count(0);
        t_bad_count(MAXB + 1);
        run_case("full", MAXB, 1, 1, 1, 1, 0);
        finished_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished_run) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule